// File: doc/BRIEF.md
# Integer Flag and Compare Unit

This unit sits next to the adder of a 32-bit integer pipeline. It holds the integer exception register, which has three live flags: a sticky summary-overflow flag, an overflow flag and a carry flag. The adder reports the carry out of the most significant bit and the carry into it. It reports both for the complete operation, including three-operand sums such as subtract-from with carry-in. The unit turns that report into flag updates according to the instruction kind and the overflow-enable bit.

The same unit evaluates integer compares. It compares a register operand against a second register, a sign-extended 16-bit immediate or a zero-extended 16-bit immediate, as a signed or unsigned compare. One cycle later it emits a 4-bit condition field, ordered less-than, greater-than, equal and summary-overflow from the most significant bit down. It emits the field with a 3-bit index that names which of eight condition subfields the field belongs in. Software reads and writes the register through a word port with byte-lane enables. Lane 3 carries the flags and lane 1 is an 8-bit scratch byte that keeps its value.

Top module: `int_flag_cmp_unit`

## Requirements
- R1: After reset, `sw_rdata` reads 0x00000000 and `cr_we` is low.
- R2: The register layout, in LSB-0 numbering, is: summary overflow at bit 31, overflow at bit 30, carry at bit 29, scratch byte at bits 15:8. A write of 0xFFFFFFFF with all lanes enabled reads back 0xE000FF00. Every other bit ignores writes and reads zero.
- R3: An update with `upd_valid`=1 and `upd_oe`=1 and kind ADD (2'd1) or ADDC (2'd2) sets overflow to `upd_co_msb` XOR `upd_co_sub`. Overflow is cleared when the two carries are equal.
- R4: Kinds NONE (2'd0) and CMP (2'd3), and any update with `upd_oe`=0, leave the overflow and summary-overflow flags unchanged.
- R5: Summary overflow is set whenever an update sets overflow. It stays set through later updates, including updates that clear overflow, until a software write to lane 3 clears it.
- R6: The carry flag takes `upd_co_msb` on every valid ADDC update, whatever the value of `upd_oe`. Every other kind holds it.
- R7: A software write that enables lane 3 overrides a same-cycle update for all three flags. A write that does not enable lane 3 leaves the same-cycle flag update in effect.
- R8: With `cmp_signed`=1 the compare is two's-complement. With `cmp_signed`=0 it is unsigned. Exactly one of `cr_field[3]` (less-than), `cr_field[2]` (greater-than) and `cr_field[1]` (equal) is set.
- R9: `cmp_src` selects the second operand: 2'd0 selects `cmp_rb`, 2'd1 selects `cmp_imm` sign-extended, 2'd2 selects `cmp_imm` zero-extended. Code 2'd3 is treated as 2'd0.
- R10: `cr_we` goes high for exactly the cycle after `cmp_valid`. In that cycle `cr_sel` equals the captured `cmp_field`, and `cr_field[0]` equals the summary-overflow flag as it stands after that cycle's update and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_be | input | 4 | Byte-lane enables for the write |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register value |
| upd_valid | input | 1 | Flag update from the adder is present |
| upd_kind | input | 2 | Instruction kind: NONE, ADD, ADDC, CMP |
| upd_oe | input | 1 | Overflow-enable bit of the instruction |
| upd_co_msb | input | 1 | Final carry out of the most significant bit |
| upd_co_sub | input | 1 | Carry out of the next bit down (into the MSB) |
| cmp_valid | input | 1 | Compare request |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_src | input | 2 | Second-operand source select |
| cmp_ra | input | 32 | First compare operand |
| cmp_rb | input | 32 | Register second operand |
| cmp_imm | input | 16 | Immediate second operand |
| cmp_field | input | 3 | Target condition subfield index |
| cr_we | output | 1 | Condition field valid |
| cr_field | output | 4 | LT, GT, EQ, SO (bit 3 down to bit 0) |
| cr_sel | output | 3 | Subfield index for `cr_field` |

## Verification
The bench builds the unit with its defaults: a 32-bit word, eight condition subfields and a 16-bit immediate. At 32 bits the exact two's-complement edges become reachable: 0x7FFFFFFF+1 and 0x80000000 minus 1, computed as a three-operand sum with carry-in. The bench also covers 0xFFFFFFFF against 1, which flips between the signed and unsigned results. The 16-bit immediate makes 0xFFFF and 0x8000 the extension cases that separate the sign-extended source from the zero-extended one. The bench walks several of the eight subfield indices and checks the sticky flag through compares that sit in the same cycle as an overflowing update.

// File: rtl/ifcu_pkg.sv
`timescale 1ns/1ps
package ifcu_pkg;

  typedef enum logic [1:0] {
    UK_NONE = 2'd0,
    UK_ADD  = 2'd1,
    UK_ADDC = 2'd2,
    UK_CMP  = 2'd3
  } upd_kind_e;

  typedef enum logic [1:0] {
    CS_REG  = 2'd0,
    CS_SIMM = 2'd1,
    CS_UIMM = 2'd2,
    CS_ALT  = 2'd3
  } cmp_src_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } xflags_t;

  // Signed overflow of the whole operation from the two top carries.
  function automatic logic ovf_of(input logic co_msb, input logic co_sub);
    return co_msb ^ co_sub;
  endfunction

  function automatic logic kind_is_arith(input logic [1:0] kind);
    return (kind == UK_ADD) || (kind == UK_ADDC);
  endfunction

endpackage

// File: rtl/ifcu_flag_next.sv
`timescale 1ns/1ps
module ifcu_flag_next
  import ifcu_pkg::*;
(
  input  xflags_t    flags_q,
  input  logic       upd_valid,
  input  logic [1:0] upd_kind,
  input  logic       upd_oe,
  input  logic       upd_co_msb,
  input  logic       upd_co_sub,
  input  logic       flag_wr,
  input  xflags_t    wr_flags,
  output xflags_t    flags_d,
  output logic       ov_set_evt,
  output logic       ca_upd_evt
);

  logic arith_upd;
  logic ov_new;

  assign arith_upd  = upd_valid && upd_oe && kind_is_arith(upd_kind);
  assign ca_upd_evt = upd_valid && (upd_kind == UK_ADDC);
  assign ov_new     = ovf_of(upd_co_msb, upd_co_sub);
  assign ov_set_evt = arith_upd && ov_new;

  always_comb begin
    flags_d = flags_q;
    if (arith_upd) begin
      flags_d.ov = ov_new;
      flags_d.so = flags_q.so | ov_new;
    end
    if (ca_upd_evt) begin
      flags_d.ca = upd_co_msb;
    end
    if (flag_wr) begin
      flags_d = wr_flags;
    end
  end

endmodule

// File: rtl/ifcu_compare.sv
`timescale 1ns/1ps
module ifcu_compare
  import ifcu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_valid,
  input  logic               cmp_signed,
  input  logic [1:0]         cmp_src,
  input  logic [DATA_W-1:0]  cmp_ra,
  input  logic [DATA_W-1:0]  cmp_rb,
  input  logic [IMM_W-1:0]   cmp_imm,
  input  logic [FIELD_W-1:0] cmp_field,
  input  logic               so_next,
  output logic               cr_we,
  output logic [3:0]         cr_field,
  output logic [FIELD_W-1:0] cr_sel
);

  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] pick_operand(
    input logic [1:0]        src,
    input logic [DATA_W-1:0] rb,
    input logic [IMM_W-1:0]  imm
  );
    case (src)
      CS_SIMM: return {{EXT_W{imm[IMM_W-1]}}, imm};
      CS_UIMM: return {{EXT_W{1'b0}}, imm};
      default: return rb;
    endcase
  endfunction

  function automatic logic [2:0] rel_bits(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              sgn
  );
    logic lt, gt;
    if (sgn) begin
      lt = $signed(a) < $signed(b);
      gt = $signed(a) > $signed(b);
    end else begin
      lt = a < b;
      gt = a > b;
    end
    return {lt, gt, a == b};
  endfunction

  logic [DATA_W-1:0] opnd_b;
  logic [2:0]        rel;

  assign opnd_b = pick_operand(cmp_src, cmp_rb, cmp_imm);
  assign rel    = rel_bits(cmp_ra, opnd_b, cmp_signed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_we    <= 1'b0;
      cr_field <= '0;
      cr_sel   <= '0;
    end else begin
      cr_we <= cmp_valid;
      if (cmp_valid) begin
        cr_field <= {rel, so_next};
        cr_sel   <= cmp_field;
      end
    end
  end

endmodule

// File: rtl/int_flag_cmp_unit.sv
`timescale 1ns/1ps
module int_flag_cmp_unit
  import ifcu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter int NUM_FIELDS = 8,
  parameter int SCR_LANE   = 1,
  localparam int BE_W      = DATA_W / 8,
  localparam int FIELD_W   = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_we,
  input  logic [BE_W-1:0]    sw_be,
  input  logic [DATA_W-1:0]  sw_wdata,
  output logic [DATA_W-1:0]  sw_rdata,
  input  logic               upd_valid,
  input  logic [1:0]         upd_kind,
  input  logic               upd_oe,
  input  logic               upd_co_msb,
  input  logic               upd_co_sub,
  input  logic               cmp_valid,
  input  logic               cmp_signed,
  input  logic [1:0]         cmp_src,
  input  logic [DATA_W-1:0]  cmp_ra,
  input  logic [DATA_W-1:0]  cmp_rb,
  input  logic [IMM_W-1:0]   cmp_imm,
  input  logic [FIELD_W-1:0] cmp_field,
  output logic               cr_we,
  output logic [3:0]         cr_field,
  output logic [FIELD_W-1:0] cr_sel
);

  localparam int SO_BIT    = DATA_W - 1;
  localparam int OV_BIT    = DATA_W - 2;
  localparam int CA_BIT    = DATA_W - 3;
  localparam int FLAG_LANE = BE_W - 1;
  localparam int SCR_LO    = SCR_LANE * 8;

  xflags_t    flags_q, flags_d, wr_flags;
  logic [7:0] scr_q;
  logic       flag_lane_wr;
  logic       scr_lane_wr;
  logic       ov_set_evt;
  logic       ca_upd_evt;

  assign flag_lane_wr = sw_we && sw_be[FLAG_LANE];
  assign scr_lane_wr  = sw_we && sw_be[SCR_LANE];
  assign wr_flags     = '{so: sw_wdata[SO_BIT], ov: sw_wdata[OV_BIT], ca: sw_wdata[CA_BIT]};

  ifcu_flag_next u_next (
    .flags_q    (flags_q),
    .upd_valid  (upd_valid),
    .upd_kind   (upd_kind),
    .upd_oe     (upd_oe),
    .upd_co_msb (upd_co_msb),
    .upd_co_sub (upd_co_sub),
    .flag_wr    (flag_lane_wr),
    .wr_flags   (wr_flags),
    .flags_d    (flags_d),
    .ov_set_evt (ov_set_evt),
    .ca_upd_evt (ca_upd_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      scr_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (scr_lane_wr) scr_q <= sw_wdata[SCR_LO +: 8];
    end
  end

  always_comb begin
    sw_rdata               = '0;
    sw_rdata[SO_BIT]       = flags_q.so;
    sw_rdata[OV_BIT]       = flags_q.ov;
    sw_rdata[CA_BIT]       = flags_q.ca;
    sw_rdata[SCR_LO +: 8]  = scr_q;
  end

  ifcu_compare #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .FIELD_W (FIELD_W)
  ) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_signed (cmp_signed),
    .cmp_src    (cmp_src),
    .cmp_ra     (cmp_ra),
    .cmp_rb     (cmp_rb),
    .cmp_imm    (cmp_imm),
    .cmp_field  (cmp_field),
    .so_next    (flags_d.so),
    .cr_we      (cr_we),
    .cr_field   (cr_field),
    .cr_sel     (cr_sel)
  );

  logic unused_inputs;
  assign unused_inputs = ^{sw_wdata, sw_be, ca_upd_evt, ov_set_evt};

endmodule

// File: rtl/ifcu_checker.sv
`timescale 1ns/1ps
module ifcu_checker #(
  parameter int DATA_W  = 32,
  parameter int BE_W    = 4,
  parameter int FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flag_lane_wr,
  input logic               ov_set_evt,
  input logic               upd_valid,
  input logic [1:0]         upd_kind,
  input logic               upd_oe,
  input logic               upd_co_msb,
  input logic               upd_co_sub,
  input logic               cmp_valid,
  input logic [FIELD_W-1:0] cmp_field,
  input logic [DATA_W-1:0]  sw_rdata,
  input logic               cr_we,
  input logic [3:0]         cr_field,
  input logic [FIELD_W-1:0] cr_sel
);

  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(7) << (DATA_W - 3)) | (DATA_W'(8'hFF) << 8);

  logic so_r, ov_r, ca_r;
  logic arith_oe;
  logic no_ov_kind;
  assign so_r = sw_rdata[DATA_W-1];
  assign ov_r = sw_rdata[DATA_W-2];
  assign ca_r = sw_rdata[DATA_W-3];
  assign arith_oe   = upd_valid && upd_oe && (upd_kind == 2'd1 || upd_kind == 2'd2);
  assign no_ov_kind = !upd_valid || !upd_oe || upd_kind == 2'd0 || upd_kind == 2'd3;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata & ~LIVE_MASK) == '0);

  // R3
  ov_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith_oe && !flag_lane_wr |=> ov_r == $past(upd_co_msb ^ upd_co_sub));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_ov_kind && !flag_lane_wr |=> $stable(ov_r) && $stable(so_r));

  // R5
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_r && !flag_lane_wr |=> so_r);

  // R5
  so_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_set_evt && !flag_lane_wr |=> so_r && ov_r);

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_kind == 2'd2) && !flag_lane_wr |=> $stable(ca_r));

  // R8
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_field[3:1]) == 1);

  // R10
  cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> cr_we && cr_sel == $past(cmp_field));

  // R10
  cmp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !cr_we);

  // R10
  cmp_so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> cr_field[0] == so_r);

endmodule

bind int_flag_cmp_unit ifcu_checker #(
  .DATA_W  (DATA_W),
  .BE_W    (BE_W),
  .FIELD_W (FIELD_W)
) u_ifcu_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flag_lane_wr (flag_lane_wr),
  .ov_set_evt   (ov_set_evt),
  .upd_valid    (upd_valid),
  .upd_kind     (upd_kind),
  .upd_oe       (upd_oe),
  .upd_co_msb   (upd_co_msb),
  .upd_co_sub   (upd_co_sub),
  .cmp_valid    (cmp_valid),
  .cmp_field    (cmp_field),
  .sw_rdata     (sw_rdata),
  .cr_we        (cr_we),
  .cr_field     (cr_field),
  .cr_sel       (cr_sel)
);

// File: tb/int_flag_cmp_unit_bench.sv
`timescale 1ns/1ps
module int_flag_cmp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_be = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_kind = '0;
  logic        upd_oe = 1'b0;
  logic        upd_co_msb = 1'b0;
  logic        upd_co_sub = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_signed = 1'b0;
  logic [1:0]  cmp_src = '0;
  logic [31:0] cmp_ra = '0;
  logic [31:0] cmp_rb = '0;
  logic [15:0] cmp_imm = '0;
  logic [2:0]  cmp_field = '0;
  logic        cr_we;
  logic [3:0]  cr_field;
  logic [2:0]  cr_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit m_so, m_ov, m_ca;
  logic [7:0] m_scr;

  always #2 clk = ~clk;

  int_flag_cmp_unit u_int_flag_cmp_unit (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_be(sw_be), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_oe(upd_oe),
    .upd_co_msb(upd_co_msb), .upd_co_sub(upd_co_sub), .cmp_valid(cmp_valid),
    .cmp_signed(cmp_signed), .cmp_src(cmp_src), .cmp_ra(cmp_ra), .cmp_rb(cmp_rb),
    .cmp_imm(cmp_imm), .cmp_field(cmp_field), .cr_we(cr_we), .cr_field(cr_field),
    .cr_sel(cr_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    return {m_so, m_ov, m_ca, 13'd0, m_scr, 8'd0};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sw_write(input logic [3:0] be, input logic [31:0] d);
    sw_we = 1'b1; sw_be = be; sw_wdata = d;
    tick();
    sw_we = 1'b0; sw_be = '0;
    if (be[3]) begin m_so = d[31]; m_ov = d[30]; m_ca = d[29]; end
    if (be[1]) m_scr = d[15:8];
  endtask

  // Drive the adder report for a + b + cin; bench derives both carries itself.
  task automatic set_upd(input logic [1:0] kind, input bit oe,
                         input logic [31:0] a, input logic [31:0] b, input bit cin);
    logic [32:0] full;
    logic [31:0] low;
    full = {1'b0, a} + {1'b0, b} + 33'(cin);
    low  = {1'b0, a[30:0]} + {1'b0, b[30:0]} + 32'(cin);
    upd_valid = 1'b1; upd_kind = kind; upd_oe = oe;
    upd_co_msb = full[32]; upd_co_sub = low[31];
  endtask

  task automatic apply_model();
    bit ovf;
    ovf = (upd_co_msb != upd_co_sub);
    if (upd_valid && upd_oe && (upd_kind == 2'd1 || upd_kind == 2'd2)) begin
      m_ov = ovf;
      if (ovf) m_so = 1'b1;
    end
    if (upd_valid && upd_kind == 2'd2) m_ca = upd_co_msb;
  endtask

  task automatic do_upd(input string req, input logic [1:0] kind, input bit oe,
                        input logic [31:0] a, input logic [31:0] b, input bit cin);
    set_upd(kind, oe, a, b, cin);
    apply_model();
    tick();
    upd_valid = 1'b0;
    check(req, sw_rdata, model_word());
  endtask

  // Bench compare: unsigned by magnitude, signed by flipping the sign bits.
  function automatic logic [3:0] exp_cmp(input logic [31:0] a, input logic [31:0] b,
                                         input bit sgn, input bit so);
    logic [31:0] x, y;
    x = sgn ? (a ^ 32'h8000_0000) : a;
    y = sgn ? (b ^ 32'h8000_0000) : b;
    if (x == y) return {3'b001, so};
    if (x < y)  return {3'b100, so};
    return {3'b010, so};
  endfunction

  task automatic do_cmp(input string req, input bit sgn, input logic [1:0] src,
                        input logic [31:0] a, input logic [31:0] b_eff, input logic [31:0] rb,
                        input logic [15:0] imm, input logic [2:0] fld);
    cmp_valid = 1'b1; cmp_signed = sgn; cmp_src = src;
    cmp_ra = a; cmp_rb = rb; cmp_imm = imm; cmp_field = fld;
    tick();
    cmp_valid = 1'b0;
    check({req, " field"}, {28'd0, cr_field}, {28'd0, exp_cmp(a, b_eff, sgn, m_so)});
    check({req, " sel"}, {29'd0, cr_sel}, {29'd0, fld});
    check({req, " we"}, {31'd0, cr_we}, 32'd1);
  endtask

  task automatic t_reset();
    m_so = 0; m_ov = 0; m_ca = 0; m_scr = '0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    check("R1 rdata", sw_rdata, 32'h0);
    check("R1 cr_we", {31'd0, cr_we}, 32'd0);
  endtask

  task automatic t_rw();
    sw_write(4'hF, 32'hFFFF_FFFF);
    check("R2 all ones", sw_rdata, 32'hE000_FF00);
    sw_write(4'hF, 32'h1234_5678);
    check("R2 pattern", sw_rdata, 32'h0000_5600);
    sw_write(4'hF, 32'h0);
    check("R2 zero", sw_rdata, 32'h0);
  endtask

  task automatic t_overflow();
    do_upd("R3 max+1", 2'd1, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    check("R3 ov word", sw_rdata, 32'hC000_0000);
    do_upd("R3 min-1", 2'd2, 1'b1, 32'h8000_0000, ~32'h1, 1'b1);
    check("R3 min-1 word", sw_rdata, 32'hE000_0000);
    do_upd("R5 clear ov keep so", 2'd1, 1'b1, 32'h1, 32'h1, 1'b0);
    check("R5 so sticky", sw_rdata, 32'hA000_0000);
    do_upd("R5 several ops", 2'd0, 1'b1, 32'h5, 32'h6, 1'b0);
    check("R5 still set", {31'd0, sw_rdata[31]}, 32'd1);
    sw_write(4'h8, 32'h0);
    check("R5 sw clear", sw_rdata, 32'h0);
  endtask

  task automatic t_no_effect();
    do_upd("R4 oe=0", 2'd1, 1'b0, 32'h7FFF_FFFF, 32'h1, 1'b0);
    do_upd("R4 cmp kind", 2'd3, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    do_upd("R4 none kind", 2'd0, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    check("R4 flags zero", sw_rdata, 32'h0);
    sw_write(4'h8, 32'h4000_0000);
    do_upd("R4 ov held", 2'd1, 1'b0, 32'h1, 32'h1, 1'b0);
    check("R4 ov word", sw_rdata, 32'h4000_0000);
    sw_write(4'h8, 32'h0);
  endtask

  task automatic t_carry();
    do_upd("R6 addc sets", 2'd2, 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0);
    check("R6 ca word", sw_rdata, 32'h2000_0000);
    do_upd("R6 add holds", 2'd1, 1'b1, 32'h0, 32'h0, 1'b0);
    check("R6 ca held", {31'd0, sw_rdata[29]}, 32'd1);
    do_upd("R6 addc clears", 2'd2, 1'b0, 32'h1, 32'h1, 1'b0);
    check("R6 ca clear", {31'd0, sw_rdata[29]}, 32'd0);
  endtask

  task automatic t_collision();
    sw_we = 1'b1; sw_be = 4'h8; sw_wdata = 32'h2000_0000;
    set_upd(2'd1, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    tick();
    sw_we = 1'b0; sw_be = '0; upd_valid = 1'b0;
    m_so = 0; m_ov = 0; m_ca = 1;
    check("R7 write wins", sw_rdata, 32'h2000_0000);
    sw_we = 1'b1; sw_be = 4'h2; sw_wdata = 32'h0000_AB00;
    set_upd(2'd1, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    apply_model();
    tick();
    sw_we = 1'b0; sw_be = '0; upd_valid = 1'b0;
    m_scr = 8'hAB;
    check("R7 scratch lane only", sw_rdata, 32'hE000_AB00);
    sw_write(4'hF, 32'h0);
  endtask

  task automatic t_compare();
    do_cmp("R8 signed -1<1", 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h1, 32'h1, 16'h0, 3'd0);
    do_cmp("R8 unsigned -1>1", 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h1, 32'h1, 16'h0, 3'd7);
    do_cmp("R8 equal", 1'b1, 2'd0, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 16'h0, 3'd3);
    do_cmp("R8 signed max>min", 1'b1, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 16'h0, 3'd5);
    do_cmp("R8 unsigned max<min", 1'b0, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 16'h0, 3'd6);
    tick();
    check("R10 we drops", {31'd0, cr_we}, 32'd0);
    sw_write(4'h8, 32'h8000_0000);
    do_cmp("R10 so copy", 1'b0, 2'd0, 32'h3, 32'h3, 32'h3, 16'h0, 3'd2);
    sw_write(4'h8, 32'h0);
    // R10: overflow in the same cycle as the compare is visible in the field.
    set_upd(2'd1, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0);
    apply_model();
    do_cmp("R10 same-cycle so", 1'b1, 2'd0, 32'h1, 32'h2, 32'h2, 16'h0, 3'd4);
    upd_valid = 1'b0;
    check("R10 so bit set", {31'd0, cr_field[0]}, 32'd1);
    sw_write(4'hF, 32'h0);
  endtask

  task automatic t_imm();
    do_cmp("R9 simm ffff", 1'b1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 3'd1);
    do_cmp("R9 uimm ffff", 1'b0, 2'd2, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 16'hFFFF, 3'd1);
    do_cmp("R9 simm 8000", 1'b1, 2'd1, 32'h0, 32'hFFFF_8000, 32'h0, 16'h8000, 3'd2);
    do_cmp("R9 code3 reg", 1'b0, 2'd3, 32'h10, 32'h20, 32'h20, 16'h0010, 3'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rw();
    t_overflow();
    t_no_effect();
    t_carry();
    t_collision();
    t_compare();
    t_imm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule